// File: doc/BRIEF.md
# USB Suspend and Resume Sequencer

This block orders the low-power transitions of a USB function that can run as host or as device. Software asks for suspend, for a short self-timed resume or for a held resume. Bus status tells the block how long the bus has been idle, whether a host transaction is still running, and whether an asynchronous wakeup was seen. From these the block drives clock gating, transceiver low power, start-of-frame generation, the resume and remote-wakeup signalling requests, and the suspend-ready and wakeup flags.

Suspend is a request followed by an acknowledge. A host waits for its current transaction to end before it gates the clock. Suspend-ready goes high one cycle after gating takes effect. A synchronized wakeup clears the request and the acknowledge in the same cycle that it raises the wakeup flag. All timing counts a microsecond made of a parameterized number of clock cycles. This lets a test build shorten the 3 ms idle window and the 50 us remote-wakeup pulse.

Top module: `usb_lp_seq`

## Requirements
- R1: After reset with device mode selected, every output is 0.
- R2: In device mode the state must be idle and power-down low. Under those conditions `idle_irq` pulses for exactly one cycle IDLE_US*TICK_CYC cycles after the last clock edge that sampled `bus_act` high. It pulses only once until new activity arrives. It never pulses in host mode.
- R3: A `susp_req` pulse sets `susp_en` at the next edge. In device mode `clk_gate` and `xcvr_lp` rise one edge later, and `susp_rdy` rises one edge after that. While suspended, `l1_req` is ignored.
- R4: In host mode `sof_en` drops at the same edge that sets `susp_en`. Clock gating does not start while `xact_busy` is high. It starts at the first edge that samples `xact_busy` low.
- R5: `wake_async` passes two synchronizer flops. On the third edge after it rises during suspend, `wake_flag` goes to 1 and `susp_en`, `susp_rdy` and `clk_gate` go to 0, all together. `wake_flag` stays set until a `wake_ack` pulse.
- R6: In device mode an `l1_req` pulse drives `rwake_drv` and `l1_busy` for exactly RWAKE_US*TICK_CYC cycles. Both then clear by themselves.
- R7: In host mode an `l1_req` pulse drives `resume_drv` for `besl_us`*TICK_CYC cycles, where a value of 0 counts as 1. `sof_en` returns at the edge where `resume_drv` drops.
- R8: Resume signalling lasts exactly as long as `l2_hold` is high, on `resume_drv` in host mode and on `rwake_drv` in device mode. In host mode `sof_en` returns at the edge that samples `l2_hold` low.
- R9: While `pwr_down` is high, from the next edge on: `xcvr_lp`=1; `sof_en`, `resume_drv`, `rwake_drv`, `clk_gate` and `susp_en` are 0; any running sequence is aborted; `susp_req` is ignored.
- R10: Of `rwake_drv`, `resume_drv` and `clk_gate`, at most one is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 selects host, 0 selects device |
| pwr_down | input | 1 | Power-down, detaches and halts sequencing |
| susp_req | input | 1 | One-cycle pulse: enter suspend |
| l1_req | input | 1 | One-cycle pulse: start the self-timed resume |
| l2_hold | input | 1 | Level: resume signalling while high |
| besl_us | input | BESL_W | Host short-resume length in microseconds |
| bus_act | input | 1 | Bus traffic seen this cycle |
| xact_busy | input | 1 | Host transaction in progress |
| wake_async | input | 1 | Asynchronous wakeup detect |
| wake_ack | input | 1 | Clears the wakeup flag |
| idle_irq | output | 1 | Idle-timeout interrupt pulse |
| susp_en | output | 1 | Suspend request status |
| susp_rdy | output | 1 | Suspend effective |
| wake_flag | output | 1 | Wakeup interrupt flag |
| clk_gate | output | 1 | USB clock gate enable |
| xcvr_lp | output | 1 | Transceiver low-power enable |
| sof_en | output | 1 | Start-of-frame generation enable |
| l1_busy | output | 1 | Self-timed resume in progress |
| rwake_drv | output | 1 | Device remote-wakeup signalling request |
| resume_drv | output | 1 | Host resume signalling request |

## Verification
The bench builds the block with TICK_CYC=2, IDLE_US=20 and RWAKE_US=5. These values bring the idle window down to 40 cycles and the device short resume down to 10 cycles. This makes exact cycle counts of both timeouts practical, as well as the once-only behaviour of the idle pulse. With BESL_W=4 the host short resume can be measured at a small setting, and at the zero setting that is promoted to one microsecond.

// File: rtl/usb_lp_pkg.sv
package usb_lp_pkg;

    typedef enum logic [4:0] {
        ST_ACT  = 5'b00001,
        ST_PEND = 5'b00010,
        ST_SUSP = 5'b00100,
        ST_L1   = 5'b01000,
        ST_L2   = 5'b10000
    } lp_state_e;

    typedef struct packed {
        lp_state_e st;
        logic      susp_en;
        logic      susp_rdy;
        logic      wake_flag;
        logic      clk_gate;
        logic      xcvr_lp;
        logic      sof_en;
        logic      l1_busy;
        logic      rwake;
        logic      resume;
    } lp_regs_t;

endpackage

// File: rtl/usb_lp_sync.sv
module usb_lp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end else begin : g_single
            always_comb sh_d = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/usb_lp_idle_mon.sv
module usb_lp_idle_mon #(
    parameter int LIMIT = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic activity,
    output logic irq
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             irq_d, irq_q;

    always_comb begin
        cnt_d = cnt_q;
        irq_d = 1'b0;
        if (!enable || activity) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
            irq_d = (cnt_q == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    // R2: the interrupt is a single-cycle pulse
    p_idle_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R2: a pulse needs the counter to be saturated at its top
    p_idle_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == TOP || cnt_q == '0));
endmodule

// File: rtl/usb_lp_res_timer.sv
module usb_lp_res_timer #(
    parameter int TICK_CYC = 48,
    parameter int DUR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DUR_W-1:0] dur_us,
    output logic             done
);
    localparam int PRE_W = $clog2(TICK_CYC + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

    logic             run_d, run_q;
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [DUR_W-1:0] rem_d, rem_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_comb begin
        run_d = run_q;
        pre_d = pre_q;
        rem_d = rem_q;
        if (start) begin
            run_d = 1'b1;
            pre_d = '0;
            rem_d = (dur_us == '0) ? DUR_W'(1) : dur_us;
        end else if (abort) begin
            run_d = 1'b0;
        end else if (run_q) begin
            if (wrap) begin
                pre_d = '0;
                if (rem_q == DUR_W'(1)) run_d = 1'b0;
                else                    rem_d = rem_q - 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            pre_q <= '0;
            rem_q <= '0;
        end else begin
            run_q <= run_d;
            pre_q <= pre_d;
            rem_q <= rem_d;
        end
    end

    assign done = run_q && wrap && (rem_q == DUR_W'(1)) && !abort;

    // R6: a running timer never holds a zero remaining count
    p_rem_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> rem_q != '0);
    // R7: completion ends the run
    p_done_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !run_q);
endmodule

// File: rtl/usb_lp_seq.sv
module usb_lp_seq
    import usb_lp_pkg::*;
#(
    parameter int TICK_CYC = 48,
    parameter int IDLE_US  = 3000,
    parameter int RWAKE_US = 50,
    parameter int BESL_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              pwr_down,
    input  logic              susp_req,
    input  logic              l1_req,
    input  logic              l2_hold,
    input  logic [BESL_W-1:0] besl_us,
    input  logic              bus_act,
    input  logic              xact_busy,
    input  logic              wake_async,
    input  logic              wake_ack,
    output logic              idle_irq,
    output logic              susp_en,
    output logic              susp_rdy,
    output logic              wake_flag,
    output logic              clk_gate,
    output logic              xcvr_lp,
    output logic              sof_en,
    output logic              l1_busy,
    output logic              rwake_drv,
    output logic              resume_drv
);
    localparam int RW_W  = $clog2(RWAKE_US + 1);
    localparam int DUR_W = (RW_W > BESL_W) ? RW_W : BESL_W;
    localparam int IDLE_LIMIT = IDLE_US * TICK_CYC;

    lp_regs_t         q, d;
    logic             wake_s;
    logic             tmr_start, tmr_done;
    logic             wake_hit;
    logic [DUR_W-1:0] dur_sel;
    logic             idle_en;

    usb_lp_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wake_async),
        .dout (wake_s)
    );

    assign idle_en = !host_mode && (q.st == ST_ACT) && !pwr_down;

    usb_lp_idle_mon #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (idle_en),
        .activity(bus_act),
        .irq     (idle_irq)
    );

    assign dur_sel = host_mode ? DUR_W'(besl_us) : DUR_W'(RWAKE_US);

    usb_lp_res_timer #(.TICK_CYC(TICK_CYC), .DUR_W(DUR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (pwr_down),
        .dur_us(dur_sel),
        .done  (tmr_done)
    );

    always_comb begin
        d         = q;
        tmr_start = 1'b0;
        wake_hit  = 1'b0;
        if (pwr_down) begin
            d.st      = ST_ACT;
            d.susp_en = 1'b0;
        end else begin
            case (q.st)
                ST_ACT: begin
                    if (susp_req) begin
                        d.susp_en = 1'b1;
                        d.st      = ST_PEND;
                    end else if (l1_req) begin
                        d.st      = ST_L1;
                        tmr_start = 1'b1;
                    end else if (l2_hold) begin
                        d.st = ST_L2;
                    end
                end
                ST_PEND: if (!(host_mode && xact_busy)) d.st = ST_SUSP;
                ST_SUSP: begin
                    if (wake_s) begin
                        d.st      = ST_ACT;
                        d.susp_en = 1'b0;
                        wake_hit  = 1'b1;
                    end
                end
                ST_L1:   if (tmr_done) d.st = ST_ACT;
                ST_L2:   if (!l2_hold) d.st = ST_ACT;
                default: d.st = ST_ACT;
            endcase
        end
        d.wake_flag = wake_hit || (q.wake_flag && !wake_ack);
        d.clk_gate  = (d.st == ST_SUSP);
        d.xcvr_lp   = (d.st == ST_SUSP) || pwr_down;
        d.susp_rdy  = (q.st == ST_SUSP) && (d.st == ST_SUSP);
        d.sof_en    = host_mode && (d.st == ST_ACT) && !pwr_down;
        d.l1_busy   = (d.st == ST_L1);
        d.rwake     = !host_mode && ((d.st == ST_L1) || (d.st == ST_L2));
        d.resume    = host_mode && ((d.st == ST_L1) || (d.st == ST_L2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_ACT;
        end else begin
            q <= d;
        end
    end

    assign susp_en    = q.susp_en;
    assign susp_rdy   = q.susp_rdy;
    assign wake_flag  = q.wake_flag;
    assign clk_gate   = q.clk_gate;
    assign xcvr_lp    = q.xcvr_lp;
    assign sof_en     = q.sof_en;
    assign l1_busy    = q.l1_busy;
    assign rwake_drv  = q.rwake;
    assign resume_drv = q.resume;

    // R10: exactly one state bit is hot
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.st) == 1);
    // R10: signalling and gating never overlap
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rwake_drv, resume_drv, clk_gate}) <= 1);
    // R3: readiness follows gating that already took effect
    p_rdy_after_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_rdy) |-> $past(clk_gate));
    // R4: frame generation is off once suspend is requested
    p_sof_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_en) |-> !sof_en);
    // R4: no gating while a host transaction is in flight
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PEND && host_mode && xact_busy && !pwr_down) |=> !clk_gate);
    // R5: request and acknowledge clear together with the flag
    p_wake_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> (!susp_en && !susp_rdy && !clk_gate));
    // R9: power-down detaches and halts everything
    p_pdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (xcvr_lp && !sof_en && !rwake_drv && !resume_drv && !clk_gate && !susp_en));
endmodule

// File: tb/test_usb_lp_seq.sv
module test_usb_lp_seq;
    localparam int TICK = 2;
    localparam int IDLE = 20;
    localparam int RW   = 5;
    localparam int BW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_mode = 1'b0, pwr_down = 1'b0, susp_req = 1'b0, l1_req = 1'b0;
    logic l2_hold = 1'b0, bus_act = 1'b0, xact_busy = 1'b0, wake_async = 1'b0, wake_ack = 1'b0;
    logic [BW-1:0] besl_us = '0;
    logic idle_irq, susp_en, susp_rdy, wake_flag, clk_gate, xcvr_lp, sof_en;
    logic l1_busy, rwake_drv, resume_drv;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    usb_lp_seq #(.TICK_CYC(TICK), .IDLE_US(IDLE), .RWAKE_US(RW), .BESL_W(BW)) i_usb_lp_seq (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .pwr_down(pwr_down),
        .susp_req(susp_req), .l1_req(l1_req), .l2_hold(l2_hold), .besl_us(besl_us),
        .bus_act(bus_act), .xact_busy(xact_busy), .wake_async(wake_async), .wake_ack(wake_ack),
        .idle_irq(idle_irq), .susp_en(susp_en), .susp_rdy(susp_rdy), .wake_flag(wake_flag),
        .clk_gate(clk_gate), .xcvr_lp(xcvr_lp), .sof_en(sof_en), .l1_busy(l1_busy),
        .rwake_drv(rwake_drv), .resume_drv(resume_drv)
    );

    task automatic chk(string req, string what, int got, int exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        chk("R1", "outputs after reset",
            int'({idle_irq, susp_en, susp_rdy, wake_flag, clk_gate, xcvr_lp, sof_en,
                  l1_busy, rwake_drv, resume_drv}), 0);
    endtask

    task automatic t_idle();
        int n;
        int pulses;
        host_mode = 1'b0;
        bus_act = 1'b1; step(); bus_act = 1'b0;
        repeat (25) step();
        chk("R2", "no pulse before window", int'(idle_irq), 0);
        bus_act = 1'b1; step(); bus_act = 1'b0;
        n = 0;
        while (!idle_irq && n < 300) begin step(); n++; end
        chk("R2", "idle window cycles", n, IDLE * TICK);
        step();
        chk("R2", "pulse width", int'(idle_irq), 0);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin step(); if (idle_irq) pulses++; end
        chk("R2", "no repeat pulse", pulses, 0);
        host_mode = 1'b1;
        bus_act = 1'b1; step(); bus_act = 1'b0;
        pulses = 0;
        for (int i = 0; i < 100; i++) begin step(); if (idle_irq) pulses++; end
        chk("R2", "no pulse in host mode", pulses, 0);
        host_mode = 1'b0;
        step();
    endtask

    task automatic t_dev_suspend();
        host_mode = 1'b0;
        susp_req = 1'b1; step(); susp_req = 1'b0;
        chk("R3", "susp_en set", int'(susp_en), 1);
        chk("R3", "gate not yet", int'(clk_gate), 0);
        step();
        chk("R3", "gate and lp", int'({clk_gate, xcvr_lp, susp_rdy}), 3'b110);
        step();
        chk("R3", "ready", int'(susp_rdy), 1);
        l1_req = 1'b1; step(); l1_req = 1'b0;
        chk("R3", "l1 ignored in suspend", int'({rwake_drv, l1_busy, clk_gate}), 3'b001);
        wake_async = 1'b1;
        step();
        chk("R5", "after sync 1", int'({wake_flag, susp_rdy}), 2'b01);
        step();
        chk("R5", "after sync 2", int'({wake_flag, susp_rdy}), 2'b01);
        step();
        chk("R5", "wake clears together",
            int'({wake_flag, susp_en, susp_rdy, clk_gate, xcvr_lp}), 5'b10000);
        wake_async = 1'b0;
        repeat (5) step();
        chk("R5", "flag sticky", int'(wake_flag), 1);
        wake_ack = 1'b1; step(); wake_ack = 1'b0;
        chk("R5", "flag acked", int'(wake_flag), 0);
    endtask

    task automatic t_host_suspend();
        host_mode = 1'b1;
        step();
        chk("R4", "sof running", int'(sof_en), 1);
        xact_busy = 1'b1;
        susp_req = 1'b1; step(); susp_req = 1'b0;
        chk("R4", "sof stops at once", int'({sof_en, susp_en}), 2'b01);
        repeat (5) step();
        chk("R4", "gate waits for busy", int'(clk_gate), 0);
        xact_busy = 1'b0;
        step();
        chk("R4", "gate after busy", int'({clk_gate, xcvr_lp}), 2'b11);
        wake_async = 1'b1;
        repeat (3) step();
        chk("R5", "host wake", int'({wake_flag, sof_en, clk_gate}), 3'b110);
        wake_async = 1'b0;
        wake_ack = 1'b1; step(); wake_ack = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_dev_l1();
        int n;
        host_mode = 1'b0;
        step();
        l1_req = 1'b1; step(); l1_req = 1'b0;
        chk("R6", "l1 busy", int'(l1_busy), 1);
        n = 0;
        while (rwake_drv && n < 500) begin
            if (resume_drv) chk("R10", "no host resume in device", 1, 0);
            n++; step();
        end
        chk("R6", "remote wakeup cycles", n, RW * TICK);
        chk("R6", "l1 self clear", int'(l1_busy), 0);
    endtask

    task automatic t_host_l1(int besl, int exp);
        int n;
        host_mode = 1'b1;
        besl_us = BW'(besl);
        step();
        l1_req = 1'b1; step(); l1_req = 1'b0;
        n = 0;
        while (resume_drv && n < 500) begin
            if (sof_en || rwake_drv) chk("R10", "no sof or rwake during resume", 1, 0);
            n++; step();
        end
        chk("R7", "host resume cycles", n, exp);
        chk("R7", "sof restarts", int'({sof_en, l1_busy}), 2'b10);
    endtask

    task automatic t_l2(logic host);
        int n;
        host_mode = host;
        step();
        l2_hold = 1'b1;
        n = 0;
        for (int i = 0; i < 17; i++) begin
            step();
            if (host ? resume_drv : rwake_drv) n++;
        end
        l2_hold = 1'b0;
        chk("R8", "held resume cycles", n, 17);
        step();
        chk("R8", "resume ends", int'({resume_drv, rwake_drv}), 0);
        chk("R8", "sof after release", int'(sof_en), int'(host));
    endtask

    task automatic t_pdown();
        host_mode = 1'b1;
        step();
        l2_hold = 1'b1;
        step();
        chk("R9", "resume before pd", int'(resume_drv), 1);
        pwr_down = 1'b1;
        step();
        chk("R9", "pd forces", int'({resume_drv, sof_en, xcvr_lp}), 3'b001);
        susp_req = 1'b1; step(); susp_req = 1'b0;
        chk("R9", "susp ignored in pd", int'({susp_en, clk_gate}), 0);
        l2_hold = 1'b0;
        pwr_down = 1'b0;
        step();
        chk("R9", "pd release", int'({sof_en, xcvr_lp, resume_drv}), 3'b100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_dev_suspend();
        t_host_suspend();
        t_dev_l1();
        t_host_l1(3, 3 * TICK);
        t_host_l1(0, TICK);
        t_l2(1'b1);
        t_l2(1'b0);
        t_pdown();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule